// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block runs a single block erase on a raw NAND device through an 8-bit shared command/address/data bus. A one-cycle `start` pulse with an 11-bit block number begins the operation. The sequencer writes the erase-setup command, three row-address bytes and the erase-confirm command, each byte latched by a WE# pulse of programmable width. It then waits for the ready/busy line to signal busy and polls the status register through RE# pulses. It ends with a one-cycle `done` pulse and a pass/fail result.

Two side paths complete the function. A reset request stops the erase at the next byte boundary and writes the reset command; after that the sequencer is idle and raises no `done`. When write-protect is low at the moment `start` arrives, the request is refused. No byte reaches the bus, and the refusal is reported in the cycle after `start`.

Top module: `nand_erase_seq`

## Requirements
- R1: An accepted erase latches exactly five bytes in this order: command 0x60, three address bytes, command 0xD0. A command byte has `cle`=1 and `ale`=0. An address byte has `ale`=1 and `cle`=0. `cle` and `ale` are never high together.
- R2: The 24-bit row address is the block number shifted left by PAGE_W (default 6) bits, with all other bits zero. The address bytes go out least significant first: row[7:0], row[15:8], row[23:16].
- R3: Each WE# pulse stays low for exactly PULSE_CLKS clocks. `io_out`, `cle` and `ale` do not change while WE# is low. WE# and RE# are never low together.
- R4: After the confirm byte, no status command (0x70) is latched until `rb_n` has been seen low. If `rb_n` stays high, polling starts after RB_WAIT clocks.
- R5: Each poll writes command 0x70 and then reads one status byte with an RE# pulse. Status bit 6 = 1 means ready. On ready, `done` pulses and `fail` takes status bit 0, where 0 means pass. The number of polls equals the number of reads needed to see bit 6 set.
- R6: When the final status has bit 0 = 1, `fail` is 1 after `done`.
- R7: After MAX_POLLS reads with bit 6 = 0, the sequencer stops polling, pulses `done` and sets `fail` to 1.
- R8: A `start` while `wp_n` is 0 produces no WE# or RE# activity. In the next cycle `done`=1, `fail`=1 and `wp_rejected`=1. The next accepted start clears `wp_rejected`.
- R9: A `rst_req` during an erase ends it once the byte in flight completes. The last byte latched is command 0xFF. No `done` follows the request. Afterwards `busy` is 0 and a new erase runs normally.
- R10: `done` is high for one clock only and never together with `busy`. `busy` is 1 from the cycle after an accepted start until the result.
- R11: After reset, `we_n`=`re_n`=1, `cle`=`ale`=`io_oe`=0, and `done`=`busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle erase request, taken only when idle |
| blk_idx | input | BLK_W | Block number to erase |
| rst_req | input | 1 | Request to abort and reset the device |
| wp_n | input | 1 | Write-protect, low refuses erases |
| rb_n | input | 1 | Device ready/busy, low = busy |
| io_in | input | 8 | Bus value read from the device |
| io_out | output | 8 | Bus value driven to the device |
| io_oe | output | 1 | Bus output enable |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Result of the last request, 1 = failed |
| wp_rejected | output | 1 | Last request refused by write-protect |
| busy | output | 1 | Operation in progress |

## Verification
The write-protect refusal is the only result with a fixed delay. `done`, `fail` and `wp_rejected` are due at the clock edge right after `start` is sampled, so the bench reads them at the next falling edge and checks that `done` has dropped one edge later. Bus bytes are captured when WE# rises, and pulse widths are counted at falling edges. Ordering and address checks therefore do not depend on how many clocks the engine spends between bytes. The erase result arrives a variable time after the last status read, so the bench waits for `done` in a bounded loop, reads `fail` in that same sample, and compares poll counts and ready-wait distances against the device model it drives.

// File: rtl/nes_pkg.sv
package nes_pkg;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_STATUS      = 8'h70;
  localparam logic [7:0] OP_RESET       = 8'hFF;
  localparam logic [7:0] ST_READY_MASK  = 8'h40;
  localparam logic [7:0] ST_FAIL_MASK   = 8'h01;

  typedef enum logic [1:0] {XF_CMD, XF_ADDR, XF_READ} xfer_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_SETUP, SQ_ADDR, SQ_CONFIRM,
    SQ_WAIT_RB, SQ_POLL_CMD, SQ_POLL_RD, SQ_RESET
  } seq_t;
endpackage

// File: rtl/nes_limit.sv
module nes_limit #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign last = (cnt == W'(LIMIT - 1));

  // R7: the counter never runs past its final value
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < W'(LIMIT));
  a_r7_no_inc_at_last: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |-> !last);
endmodule

// File: rtl/nes_strobe.sv
module nes_strobe
  import nes_pkg::*;
#(
  parameter int PULSE_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  xfer_t      kind,
  input  logic [7:0] byte_in,
  input  logic [7:0] io_in,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic       ack,
  output logic       rd_ready,
  output logic       rd_fail
);
  localparam int CW = $clog2(PULSE_CLKS + 1);
  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HOLD} phase_t;

  phase_t        ph;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      io_out   <= '0;
      io_oe    <= 1'b0;
      cle      <= 1'b0;
      ale      <= 1'b0;
      we_n     <= 1'b1;
      re_n     <= 1'b1;
      ack      <= 1'b0;
      rd_ready <= 1'b0;
      rd_fail  <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (ph)
        PH_IDLE: if (go) begin
          io_out <= byte_in;
          io_oe  <= (kind != XF_READ);
          cle    <= (kind == XF_CMD);
          ale    <= (kind == XF_ADDR);
          we_n   <= (kind == XF_READ);
          re_n   <= (kind != XF_READ);
          cnt    <= CW'(PULSE_CLKS - 1);
          ph     <= PH_LOW;
        end
        PH_LOW: begin
          if (cnt == '0) begin
            we_n <= 1'b1;
            re_n <= 1'b1;
            if (!re_n) begin
              rd_ready <= |(io_in & ST_READY_MASK);
              rd_fail  <= |(io_in & ST_FAIL_MASK);
            end
            ph <= PH_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          cle   <= 1'b0;
          ale   <= 1'b0;
          io_oe <= 1'b0;
          ack   <= 1'b1;
          ph    <= PH_IDLE;
        end
      endcase
    end
  end

  // R1: command and address latches are exclusive
  a_r1_latch_excl: assert property (@(posedge clk) disable iff (rst)
    !(cle && ale));
  // R3: bus content is frozen during a write pulse
  a_r3_bus_stable: assert property (@(posedge clk) disable iff (rst)
    (!we_n && $past(!we_n)) |-> ($stable(io_out) && $stable(cle) && $stable(ale)));
  // R3: never both strobes active
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));
  // R3: a write rising edge always carries a driven, qualified byte
  a_r3_rise_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (io_oe && (cle || ale)));
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
  import nes_pkg::*;
#(
  parameter int BLK_W      = 11,
  parameter int PAGE_W     = 6,
  parameter int PULSE_CLKS = 2,
  parameter int MAX_POLLS  = 1000,
  parameter int RB_WAIT    = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [BLK_W-1:0] blk_idx,
  input  logic             rst_req,
  input  logic             wp_n,
  input  logic             rb_n,
  input  logic [7:0]       io_in,
  output logic [7:0]       io_out,
  output logic             io_oe,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic             done,
  output logic             fail,
  output logic             wp_rejected,
  output logic             busy
);
  localparam int ROW_W = 24;

  seq_t             st;
  logic             issued, rst_pend;
  logic [1:0]       addr_idx;
  logic [ROW_W-1:0] row_q;
  logic             go, ack, rd_ready, rd_fail;
  logic             hold, take_abort, byte_state;
  xfer_t            kind;
  logic [7:0]       xbyte;
  logic             rb_clr, rb_inc, rb_last;
  logic             poll_clr, poll_inc, poll_last;

  assign byte_state = (st == SQ_SETUP) || (st == SQ_ADDR) || (st == SQ_CONFIRM) ||
                      (st == SQ_POLL_CMD) || (st == SQ_POLL_RD) || (st == SQ_RESET);
  assign hold       = (rst_pend || rst_req) && (st != SQ_RESET);
  assign take_abort = hold && (!issued || ack);
  assign go         = byte_state && !issued && !hold;

  always_comb begin
    kind  = XF_CMD;
    xbyte = 8'h00;
    case (st)
      SQ_SETUP:    xbyte = OP_ERASE_SETUP;
      SQ_CONFIRM:  xbyte = OP_ERASE_GO;
      SQ_POLL_CMD: xbyte = OP_STATUS;
      SQ_RESET:    xbyte = OP_RESET;
      SQ_POLL_RD:  kind  = XF_READ;
      SQ_ADDR: begin
        kind = XF_ADDR;
        case (addr_idx)
          2'd0:    xbyte = row_q[7:0];
          2'd1:    xbyte = row_q[15:8];
          default: xbyte = row_q[23:16];
        endcase
      end
      default: ;
    endcase
  end

  assign rb_clr   = (st != SQ_WAIT_RB);
  assign rb_inc   = (st == SQ_WAIT_RB) && rb_n && !rb_last;
  assign poll_clr = (st == SQ_IDLE);
  assign poll_inc = (st == SQ_POLL_RD) && ack && !take_abort && !rd_ready && !poll_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= SQ_IDLE;
      issued      <= 1'b0;
      rst_pend    <= 1'b0;
      addr_idx    <= '0;
      row_q       <= '0;
      done        <= 1'b0;
      fail        <= 1'b0;
      wp_rejected <= 1'b0;
      busy        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take_abort) begin
        st       <= SQ_RESET;
        issued   <= 1'b0;
        rst_pend <= 1'b0;
        busy     <= 1'b1;
      end else begin
        if (go) issued <= 1'b1;
        if (rst_req && st != SQ_RESET) rst_pend <= 1'b1;
        case (st)
          SQ_IDLE: if (start) begin
            if (!wp_n) begin
              done        <= 1'b1;
              fail        <= 1'b1;
              wp_rejected <= 1'b1;
            end else begin
              wp_rejected <= 1'b0;
              fail        <= 1'b0;
              busy        <= 1'b1;
              row_q       <= ROW_W'(blk_idx) << PAGE_W;
              addr_idx    <= '0;
              st          <= SQ_SETUP;
            end
          end
          SQ_SETUP: if (ack) begin
            issued <= 1'b0;
            st     <= SQ_ADDR;
          end
          SQ_ADDR: if (ack) begin
            issued <= 1'b0;
            if (addr_idx == 2'd2) st <= SQ_CONFIRM;
            else addr_idx <= addr_idx + 1'b1;
          end
          SQ_CONFIRM: if (ack) begin
            issued <= 1'b0;
            st     <= SQ_WAIT_RB;
          end
          SQ_WAIT_RB: if (!rb_n || rb_last) st <= SQ_POLL_CMD;
          SQ_POLL_CMD: if (ack) begin
            issued <= 1'b0;
            st     <= SQ_POLL_RD;
          end
          SQ_POLL_RD: if (ack) begin
            issued <= 1'b0;
            if (rd_ready || poll_last) begin
              done <= 1'b1;
              fail <= rd_ready ? rd_fail : 1'b1;
              busy <= 1'b0;
              st   <= SQ_IDLE;
            end else begin
              st <= SQ_POLL_CMD;
            end
          end
          SQ_RESET: if (ack) begin
            issued <= 1'b0;
            busy   <= 1'b0;
            st     <= SQ_IDLE;
          end
          default: st <= SQ_IDLE;
        endcase
      end
    end
  end

  nes_strobe #(.PULSE_CLKS(PULSE_CLKS)) u_strobe (
    .clk(clk), .rst(rst), .go(go), .kind(kind), .byte_in(xbyte), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .ack(ack), .rd_ready(rd_ready), .rd_fail(rd_fail)
  );

  nes_limit #(.LIMIT(RB_WAIT)) u_rb_wait (
    .clk(clk), .rst(rst), .clr(rb_clr), .inc(rb_inc), .last(rb_last)
  );

  nes_limit #(.LIMIT(MAX_POLLS)) u_poll_cnt (
    .clk(clk), .rst(rst), .clr(poll_clr), .inc(poll_inc), .last(poll_last)
  );

  // R10: completion is a single-cycle pulse outside the busy window
  a_r10_single_done: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R9: a reset request never yields a completion pulse
  a_r9_abort_no_done: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !done);
  // R8: a protected request is refused in the next cycle
  a_r8_wp_reject: assert property (@(posedge clk) disable iff (rst)
    (start && !wp_n && !busy && !rst_req) |=> (done && wp_rejected && fail));
endmodule

// File: tb/sim_nand_erase_seq.sv
module sim_nand_erase_seq;
  localparam int PULSE = 3;
  localparam int MAXP  = 5;
  localparam int RBW   = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [10:0] blk_idx = '0;
  logic        rst_req = 1'b0;
  logic        wp_n = 1'b1;
  logic        rb_n = 1'b1;
  logic [7:0]  io_in;
  logic [7:0]  io_out;
  logic        io_oe, cle, ale, we_n, re_n, done, fail, wp_rejected, busy;

  int nchk = 0, nbad = 0;
  int cyc = 0, nlat = 0, n70 = 0, nre = 0, ndone = 0, bad_w = 0, done_long = 0, lowcnt = 0;
  int base70 = 0, ready_after = 1;
  logic fail_bit = 1'b0;
  logic prev_we = 1'b1, prev_re = 1'b1, prev_done = 1'b0;
  logic [9:0] lat [256];
  int lat_cyc [256];

  always #5 clk = ~clk;

  nand_erase_seq #(.PULSE_CLKS(PULSE), .MAX_POLLS(MAXP), .RB_WAIT(RBW)) u0 (
    .clk(clk), .rst(rst), .start(start), .blk_idx(blk_idx), .rst_req(rst_req),
    .wp_n(wp_n), .rb_n(rb_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
    .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .done(done), .fail(fail),
    .wp_rejected(wp_rejected), .busy(busy)
  );

  assign io_in = (!re_n && (n70 - base70) >= ready_after) ?
                 {1'b0, 1'b1, 5'b0, fail_bit} : 8'h00;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!prev_we && we_n) begin
      lat[nlat % 256]     = {cle, ale, io_out};
      lat_cyc[nlat % 256] = cyc;
      if (cle && io_out == 8'h70) n70 = n70 + 1;
      if (lowcnt != PULSE) bad_w = bad_w + 1;
      nlat = nlat + 1;
    end
    lowcnt = we_n ? 0 : lowcnt + 1;
    if (prev_re && !re_n) nre = nre + 1;
    if (done && prev_done) done_long = done_long + 1;
    if (done) ndone = ndone + 1;
    prev_we   = we_n;
    prev_re   = re_n;
    prev_done = done;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_erase(input logic [10:0] blk, input int rdy, input logic fb,
                           input int rb_delay, input logic exp_fail,
                           input int exp_polls, input string freq);
    int b0, s70, w0, dl0;
    logic [23:0] row;
    b0 = nlat; s70 = n70; w0 = bad_w; dl0 = done_long;
    base70 = n70; ready_after = rdy; fail_bit = fb; rb_n = 1'b1;
    row = {13'b0, blk} << 6;
    @(negedge clk); blk_idx = blk; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after start", busy, 1);
    for (int i = 0; i < 400; i++) begin
      if (nlat >= b0 + 5) break;
      @(negedge clk);
    end
    chk(lat[b0 % 256] == {2'b10, 8'h60}, "R1", "setup byte", lat[b0 % 256], {2'b10, 8'h60});
    chk(lat[(b0+1) % 256] == {2'b01, row[7:0]}, "R2", "addr byte 0", lat[(b0+1) % 256], {2'b01, row[7:0]});
    chk(lat[(b0+2) % 256] == {2'b01, row[15:8]}, "R2", "addr byte 1", lat[(b0+2) % 256], {2'b01, row[15:8]});
    chk(lat[(b0+3) % 256] == {2'b01, row[23:16]}, "R2", "addr byte 2", lat[(b0+3) % 256], {2'b01, row[23:16]});
    chk(lat[(b0+4) % 256] == {2'b10, 8'hD0}, "R1", "confirm byte", lat[(b0+4) % 256], {2'b10, 8'hD0});
    if (rb_delay >= 0) begin
      repeat (rb_delay) @(negedge clk);
      chk(n70 == s70, "R4", "status cmds before busy", n70 - s70, 0);
      rb_n = 1'b0;
    end
    for (int i = 0; i < 20000; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk(done == 1'b1, "R5", "done seen", done, 1);
    chk(fail == exp_fail, freq, "fail flag", fail, exp_fail);
    chk(n70 - s70 == exp_polls, freq, "status polls", n70 - s70, exp_polls);
    if (rb_delay < 0)
      chk(lat_cyc[(b0+5) % 256] - lat_cyc[(b0+4) % 256] >= RBW, "R4", "ready wait length",
          lat_cyc[(b0+5) % 256] - lat_cyc[(b0+4) % 256], RBW);
    @(negedge clk);
    chk(done == 1'b0 && done_long == dl0, "R10", "done width", done, 0);
    chk(busy == 1'b0, "R10", "busy after done", busy, 0);
    chk(bad_w == w0, "R3", "we low width errors", bad_w - w0, 0);
    rb_n = 1'b1;
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(we_n && re_n && !cle && !ale && !io_oe, "R11", "bus idle after reset",
        {we_n, re_n, cle, ale, io_oe}, 5'b11000);
    chk(!done && !busy, "R11", "status idle after reset", {done, busy}, 0);
  endtask

  task automatic t_wp;
    int b0, r0;
    b0 = nlat; r0 = nre;
    @(negedge clk); wp_n = 1'b0; blk_idx = 11'h0AA; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done && wp_rejected && fail && !busy, "R8", "refusal flags",
        {done, wp_rejected, fail, busy}, 4'b1110);
    @(negedge clk);
    chk(done == 1'b0, "R8", "refusal done width", done, 0);
    repeat (30) @(negedge clk);
    chk(nlat == b0 && nre == r0, "R8", "strobes while protected", nlat - b0 + nre - r0, 0);
    wp_n = 1'b1;
    run_erase(11'h011, 1, 1'b0, 3, 1'b0, 1, "R5");
    chk(wp_rejected == 1'b0, "R8", "flag cleared by accepted start", wp_rejected, 0);
  endtask

  task automatic t_abort;
    int b0, s70, d0, nr, na;
    b0 = nlat; s70 = n70; base70 = n70; ready_after = 100; fail_bit = 1'b0;
    @(negedge clk); blk_idx = 11'h3C3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (nlat >= b0 + 5) break;
      @(negedge clk);
    end
    rb_n = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (n70 >= s70 + 2) break;
      @(negedge clk);
    end
    d0 = ndone;
    rst_req = 1'b1;
    @(negedge clk); rst_req = 1'b0;
    repeat (40) @(negedge clk);
    nr = nlat;
    chk(lat[(nr-1) % 256] == {2'b10, 8'hFF}, "R9", "last byte is reset cmd",
        lat[(nr-1) % 256], {2'b10, 8'hFF});
    chk(ndone == d0, "R9", "no done after abort", ndone - d0, 0);
    chk(busy == 1'b0, "R9", "idle after abort", busy, 0);
    repeat (10) @(negedge clk);
    na = nlat;
    chk(na == nr, "R9", "bus quiet after reset cmd", na - nr, 0);
    rb_n = 1'b1;
    run_erase(11'h200, 2, 1'b0, 4, 1'b0, 2, "R9");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    t_reset();
    run_erase(11'h5A3, 3, 1'b0, 20, 1'b0, 3, "R5");
    run_erase(11'h7FF, 1, 1'b1, 5, 1'b1, 1, "R6");
    run_erase(11'h000, 2, 1'b0, 8, 1'b0, 2, "R5");
    run_erase(11'h123, 100, 1'b0, -1, 1'b1, MAXP, "R7");
    t_wp();
    t_abort();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule